// File: doc/BRIEF.md
# Real-Time Clock Interrupt and Status Unit

This block gathers the event side of a real-time clock. It takes a once-per-second strobe and the current seconds, minutes and hours, and can raise a periodic timer interrupt every second, minute, hour or day. It also takes a strobe from an external alarm comparator and turns it into a sticky alarm flag that drives its own interrupt line. Time counting and alarm comparison happen elsewhere. This unit only decides which events get recorded and when they are cleared.

Software uses a byte-wide register port with two locations. Address 0 holds the interrupt-enable byte and address 1 holds the status byte. The periodic event flags clear when status is read. The alarm flag and the power-up flag stay set until software clears them with a write that uses a defined bit polarity.

Top module: `rtc_irq_status`

## Requirements
- R1: After reset, the enable byte reads 0x00, the status byte reads 0x80 (bit 7 is the power-up flag) and both interrupt outputs are low.
- R2: A write to address 0 stores the byte in the enable register. The register reads back unchanged. Bit 3 enables the alarm, bit 2 enables the periodic timer, and bits 1:0 select the period (0 second, 1 minute, 2 hour, 3 day).
- R3: With the periodic timer enabled and period 0, every tick sets status bit 2. The timer interrupt output is the OR of status bits 5:2, so it is high from the cycle after that edge.
- R4: The minute period sets status bit 3 on a tick only when seconds are zero. The hour period sets bit 4 only when seconds and minutes are zero. The day period sets bit 5 only when seconds, minutes and hours are all zero.
- R5: With enable bit 2 clear, ticks set no status bit and the timer output stays low.
- R6: An alarm strobe with enable bit 3 set sets status bit 6. The alarm output always equals status bit 6. With bit 3 clear, the strobe is ignored.
- R7: A status read returns the value held before the read, then clears bits 0 and 5:2. Bits 7, 6 and 1 are kept.
- R8: A status write clears bit 6 when data bit 6 is 1 and clears bit 7 when data bit 7 is 0. No other status bit changes.
- R9: Status bit 1 shows the run input as sampled at the previous clock edge.
- R10: When a periodic event and a status read fall in the same cycle, the read returns the old value and the new event bit stays set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| cur_sec | input | SEC_W | Current seconds, binary |
| cur_min | input | MIN_W | Current minutes, binary |
| cur_hour | input | HR_W | Current hours, binary |
| alarm_hit | input | 1 | One-cycle strobe from the alarm comparator |
| run_flag | input | 1 | Run bit of the clock control register |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 1 | 0 = enable, 1 = status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| tmr_irq | output | 1 | Periodic timer interrupt, level |
| alarm_irq | output | 1 | Alarm interrupt, level |

## Verification
The bench walks each period setting. It sends ticks where only some of the time fields are zero, so a design that ignores minutes or hours in its gating would record hour or day events too early. It reads status twice after the alarm, so a design that clears bit 6 or bit 7 on a read would show up. It writes status patterns that have the wrong polarity for clearing, so a design that treats the write as plain write-one-to-clear would drop the power-up flag or lose a pending periodic bit. It also puts a tick and a status read in the same cycle, so a design that lets the read win would lose that event.

// File: rtl/rtc_irq_status.sv
module rtc_irq_status #(
  parameter int SEC_W = 6,
  parameter int MIN_W = 6,
  parameter int HR_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic [SEC_W-1:0] cur_sec,
  input  logic [MIN_W-1:0] cur_min,
  input  logic [HR_W-1:0]  cur_hour,
  input  logic             alarm_hit,
  input  logic             run_flag,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             tmr_irq,
  output logic             alarm_irq
);
  localparam logic [7:0] RD_CLR_MASK = 8'h3D;
  localparam logic [7:0] STAT_RESET  = 8'h80;
  localparam int B_ALM_EN = 3;
  localparam int B_PER_EN = 2;
  localparam int B_ALM    = 6;
  localparam int B_PWR    = 7;
  localparam int B_RUN    = 1;

  logic [7:0] irq_en, stat, stat_nxt;
  logic       period_ok;
  logic [3:0] per_ev;

  wire wr_en   = reg_sel &  reg_wr & ~reg_addr;
  wire wr_stat = reg_sel &  reg_wr &  reg_addr;
  wire rd_stat = reg_sel & ~reg_wr &  reg_addr;
  wire sec_z   = (cur_sec  == '0);
  wire min_z   = (cur_min  == '0);
  wire hr_z    = (cur_hour == '0);
  wire alm_set = alarm_hit & irq_en[B_ALM_EN];

  always_comb begin
    case (irq_en[1:0])
      2'd0:    period_ok = 1'b1;
      2'd1:    period_ok = sec_z;
      2'd2:    period_ok = sec_z & min_z;
      default: period_ok = sec_z & min_z & hr_z;
    endcase
    per_ev = (sec_tick & irq_en[B_PER_EN] & period_ok) ? (4'b0001 << irq_en[1:0]) : 4'b0000;
  end

  always_comb begin
    stat_nxt = stat;
    if (rd_stat) stat_nxt = stat_nxt & ~RD_CLR_MASK;
    if (wr_stat) begin
      if (reg_wdata[B_ALM])  stat_nxt[B_ALM] = 1'b0;
      if (!reg_wdata[B_PWR]) stat_nxt[B_PWR] = 1'b0;
    end
    stat_nxt[5:2]   = stat_nxt[5:2] | per_ev;
    stat_nxt[B_ALM] = stat_nxt[B_ALM] | alm_set;
    stat_nxt[B_RUN] = run_flag;
    stat_nxt[0]     = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en <= 8'h00;
      stat   <= STAT_RESET;
    end else begin
      if (wr_en) irq_en <= reg_wdata;
      stat <= stat_nxt;
    end
  end

  assign reg_rdata = reg_addr ? stat : irq_en;
  assign tmr_irq   = |stat[5:2];
  assign alarm_irq = stat[B_ALM];

  assert_second_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && irq_en[B_PER_EN] && irq_en[1:0] == 2'd0) |=> tmr_irq);

  assert_quiet_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !rd_stat) |=> $stable(stat[5:2]));

  assert_alarm_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_hit && irq_en[B_ALM_EN]) |=> alarm_irq);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !sec_tick) |=> !tmr_irq);

  assert_read_keeps_alarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !wr_stat && alarm_irq) |=> alarm_irq);

  assert_pwr_never_rises_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(stat[B_PWR]));

  assert_pwr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !reg_wdata[B_PWR]) |=> !stat[B_PWR]);

  assert_run_mirror_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat[B_RUN] == $past(run_flag)));

  assert_event_beats_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && sec_tick && irq_en[B_PER_EN] && irq_en[1:0] == 2'd0) |=> stat[2]);
endmodule

// File: tb/tb_rtc_irq_status.sv
module tb_rtc_irq_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [5:0] cur_sec = '0;
  logic [5:0] cur_min = '0;
  logic [4:0] cur_hour = '0;
  logic       alarm_hit = 1'b0;
  logic       run_flag = 1'b0;
  logic       reg_sel = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tmr_irq, alarm_irq;
  logic       pin_req = 1'b0;

  typedef struct { bit pins; logic [7:0] exp; string tag; } item_t;
  item_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  rtc_irq_status dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cur_sec(cur_sec),
    .cur_min(cur_min), .cur_hour(cur_hour), .alarm_hit(alarm_hit),
    .run_flag(run_flag), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tmr_irq(tmr_irq), .alarm_irq(alarm_irq));

  always @(negedge clk) begin
    logic [7:0] act;
    item_t it;
    if ((reg_sel && !reg_wr) || pin_req) begin
      act = pin_req ? {6'b0, tmr_irq, alarm_irq} : reg_rdata;
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL monitor: unexpected sample, actual %02h expected none", act);
      end else begin
        it = exp_q.pop_front();
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_sel = 0; reg_wr = 0;
  endtask

  task automatic rd(input logic a, input logic [7:0] e, input string tag, input bit with_tick = 0);
    item_t it;
    it.pins = 0; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    reg_sel = 1; reg_wr = 0; reg_addr = a; sec_tick = with_tick;
    step();
    reg_sel = 0; sec_tick = 0;
  endtask

  task automatic pins(input bit t, input bit al, input string tag);
    item_t it;
    it.pins = 1; it.exp = {6'b0, t, al}; it.tag = tag;
    exp_q.push_back(it);
    pin_req = 1;
    step();
    pin_req = 0;
  endtask

  task automatic tick(input int s, input int m, input int h);
    cur_sec = 6'(s); cur_min = 6'(m); cur_hour = 5'(h); sec_tick = 1;
    step();
    sec_tick = 0;
  endtask

  task automatic alarm();
    alarm_hit = 1; step(); alarm_hit = 0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    rd(0, 8'h00, "R1 enable after reset");
    rd(1, 8'h80, "R1 status after reset");
    pins(0, 0, "R1 outputs after reset");

    wr(0, 8'h04);
    rd(0, 8'h04, "R2 enable readback");
    tick(17, 3, 9);
    pins(1, 0, "R3 timer output after second tick");
    rd(1, 8'h84, "R3 second bit set");
    rd(1, 8'h80, "R7 periodic bit cleared by read");
    pins(0, 0, "R7 timer output low after read");

    wr(0, 8'h05);
    tick(5, 0, 0);
    rd(1, 8'h80, "R4 minute needs zero seconds");
    tick(0, 7, 2);
    rd(1, 8'h88, "R4 minute event");
    wr(0, 8'h06);
    tick(0, 3, 0);
    rd(1, 8'h80, "R4 hour needs zero minutes");
    tick(0, 0, 5);
    rd(1, 8'h90, "R4 hour event");
    wr(0, 8'h07);
    tick(0, 0, 1);
    rd(1, 8'h80, "R4 day needs zero hours");
    tick(0, 0, 0);
    rd(1, 8'hA0, "R4 day event");

    wr(0, 8'h00);
    tick(0, 0, 0);
    rd(1, 8'h80, "R5 disabled timer sets nothing");
    alarm();
    pins(0, 0, "R6 alarm ignored when disabled");

    wr(0, 8'h08);
    alarm();
    pins(0, 1, "R6 alarm output");
    rd(1, 8'hC0, "R6 alarm bit set");
    rd(1, 8'hC0, "R7 read keeps alarm and power-up bits");

    wr(0, 8'h0C);
    tick(30, 1, 1);
    wr(1, 8'hBF);
    rd(1, 8'hC4, "R8 wrong-polarity write changes nothing");
    wr(1, 8'hC0);
    rd(1, 8'h80, "R8 write one to bit 6 clears alarm");
    pins(0, 0, "R8 alarm output low after clear");
    wr(1, 8'h40);
    rd(1, 8'h00, "R8 write zero to bit 7 clears power-up flag");

    run_flag = 1;
    step();
    rd(1, 8'h02, "R9 run bit mirrored");
    rd(1, 8'h02, "R9 run bit survives read");
    run_flag = 0;
    step();

    wr(0, 8'h04);
    cur_sec = 6'd9;
    rd(1, 8'h00, "R10 read in event cycle returns old value", 1);
    rd(1, 8'h04, "R10 event kept after simultaneous read");

    step();
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: actual %0d leftover expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule